// File: doc/BRIEF.md
# Serial Controller Interrupt and Control Register Unit

This unit sits beside a clocked serial engine and its two FIFOs. It holds one control word and one interrupt status word, both reached through a plain 32-bit write/read port. The engine and FIFOs report events as single-cycle pulses. Each pulse sets a sticky status bit. Software clears a status bit by writing a 1 to it. A single interrupt request line is raised whenever any status bit is set and its enable bit is also set.

There are six event sources:

| Source | Bit |
|---|---|
| Receive-trigger | 0 |
| Transmit-FIFO-empty | 4 |
| Transfer-done | 8 |
| Transmission-done | 9 |
| Receive overflow | 12 |
| Transmit underrun | 13 |

Each source's enable bit sits at the same position in the control word as its status bit does in the status word. The control word carries two further bits. Bit 19 turns on the receive-trigger mechanism in the datapath. Bit 28 is a software reset: while it is set, the core is held in reset and the busy indication sent to software is forced low. The control word sits at byte address 0 and the status word at byte address 4.

Top module: `isr_unit`

## Requirements
- R1: After reset, the control word and the status word both read 0, the interrupt request is low, the core reset output is low and the receive-trigger enable is low.
- R2: An event pulse on source index k (0 to 5) sets status bit 0, 4, 8, 9, 12 or 13 respectively at the next clock edge. This happens whether or not the matching enable bit is set.
- R3: A write to the status word (address 4) clears each status bit whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R4: If an event pulse and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R5: The interrupt request is high exactly when at least one status bit is 1 and the control bit at the same position is 1.
- R6: The control word (address 0) stores bits 0, 4, 8, 9, 12, 13, 19 and 28 as written and reads them back. Every other control bit reads 0.
- R7: While control bit 28 is 1, the core reset output is 1 and the busy output is 0 even when the engine reports busy. When bit 28 is 0, the busy output follows the engine.
- R8: Control bit 19 drives the receive-trigger enable output.
- R9: Writing the status word leaves the control word unchanged, and writing the control word leaves the status word unchanged. Status bits other than the six event positions always read 0.
- R10: A write to any address other than 0 or 4 changes neither word. Reading such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Write strobe for the register port |
| regAddr | input | 4 | Byte address for read and write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| evtPulse | input | 6 | Event pulses, index 0..5 map to status bits 0,4,8,9,12,13 |
| engineBusy | input | 1 | Busy indication from the serial engine |
| irqReq | output | 1 | Interrupt request |
| coreRst | output | 1 | Holds the core in reset (control bit 28) |
| busyOut | output | 1 | Busy indication as seen by software |
| rxTrigEn | output | 1 | Receive-trigger mechanism enable (control bit 19) |

## Verification
The bench builds the unit with its default parameters: a 4-bit address, the control word at 0 and the status word at 4. With six sources, every combination of enable mask and latched status can be driven; that is 4096 pairs, and for each pair the interrupt line and the status readback are compared with an arithmetic model. A second sweep applies all 64 clear masks, with the reserved bits set on half of them. A third sweep, over each source, lands an event and a clear in the same cycle. Software reset, the receive-trigger enable and writes to an unmapped address are each driven through the register port and checked at the outputs.

// File: rtl/isr_pkg.sv
package isr_pkg;

  localparam int REG_W   = 32;
  localparam int NUM_SRC = 6;

  // Bit position of each event source in both the status and control words
  localparam int SRC_POS [NUM_SRC] = '{0, 4, 8, 9, 12, 13};

  localparam int RXTRG_BIT = 19;
  localparam int SRST_BIT  = 28;

  function automatic logic [REG_W-1:0] calcSrcMask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_SRC; i++) m[SRC_POS[i]] = 1'b1;
    return m;
  endfunction

  localparam logic [REG_W-1:0] SRC_MASK  = calcSrcMask();
  localparam logic [REG_W-1:0] CTRL_MASK = SRC_MASK
                                         | (REG_W'(1) << RXTRG_BIT)
                                         | (REG_W'(1) << SRST_BIT);

  typedef struct packed {
    logic             ctrlWr;
    logic             statWr;
    logic [REG_W-1:0] data;
  } regStrobe_t;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_STAT = 2'd2
  } rdSel_e;

endpackage

// File: rtl/isr_decode.sv
module isr_decode
  import isr_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CTRL_ADDR = 0,
  parameter int STAT_ADDR = 4
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output regStrobe_t        strb,
  output rdSel_e            rdSel
);

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

  logic hitCtrl;
  logic hitStat;

  assign hitCtrl = (regAddr == CTRL_A);
  assign hitStat = (regAddr == STAT_A);

  always_comb begin
    strb.ctrlWr = regWrEn && hitCtrl;
    strb.statWr = regWrEn && hitStat;
    strb.data   = regWrData;
  end

  always_comb begin
    if (hitCtrl)      rdSel = SEL_CTRL;
    else if (hitStat) rdSel = SEL_STAT;
    else              rdSel = SEL_NONE;
  end

  // Decode never targets both words at once
  always_comb begin
    assert_one_target_R10: assert (!(strb.ctrlWr && strb.statWr));
  end

endmodule

// File: rtl/isr_datapath.sv
module isr_datapath
  import isr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         strb,
  input  rdSel_e             rdSel,
  input  logic [NUM_SRC-1:0] evtPulse,
  input  logic               engineBusy,
  output logic [REG_W-1:0]   rdData,
  output logic               irqReq,
  output logic               coreRst,
  output logic               busyOut,
  output logic               rxTrigEn
);

  logic [REG_W-1:0]   ctrlQ;
  logic [NUM_SRC-1:0] statQ;
  logic [NUM_SRC-1:0] enVec;
  logic [REG_W-1:0]   statWord;

  // Control word: only defined bits are stored
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            ctrlQ <= '0;
    else if (strb.ctrlWr) ctrlQ <= strb.data & CTRL_MASK;
  end

  // Sticky status bits, event has priority over clear
  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    logic clrHit;
    assign clrHit   = strb.statWr && strb.data[SRC_POS[g]];
    assign enVec[g] = ctrlQ[SRC_POS[g]];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            statQ[g] <= 1'b0;
      else if (evtPulse[g]) statQ[g] <= 1'b1;
      else if (clrHit)      statQ[g] <= 1'b0;
    end

    assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
      evtPulse[g] |=> statQ[g]);
    assert_evt_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
      (evtPulse[g] && clrHit) |=> statQ[g]);
    assert_w1c_R3: assert property (@(posedge clk) disable iff (!rstN)
      (clrHit && !evtPulse[g]) |=> !statQ[g]);
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
      (!clrHit && !evtPulse[g]) |=> $stable(statQ[g]));
  end

  always_comb begin
    statWord = '0;
    for (int i = 0; i < NUM_SRC; i++) statWord[SRC_POS[i]] = statQ[i];
  end

  always_comb begin
    case (rdSel)
      SEL_CTRL: rdData = ctrlQ;
      SEL_STAT: rdData = statWord;
      default:  rdData = '0;
    endcase
  end

  assign irqReq   = |(statQ & enVec);
  assign coreRst  = ctrlQ[SRST_BIT];
  assign rxTrigEn = ctrlQ[RXTRG_BIT];
  assign busyOut  = engineBusy && !coreRst;

  assert_ctrl_keep_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ctrlWr |=> $stable(ctrlQ));
  assert_rxtrg_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.ctrlWr |=> (rxTrigEn == $past(strb.data[RXTRG_BIT])));

endmodule

// File: rtl/isr_unit.sv
module isr_unit
  import isr_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CTRL_ADDR = 0,
  parameter int STAT_ADDR = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [REG_W-1:0]   regWrData,
  output logic [REG_W-1:0]   regRdData,
  input  logic [NUM_SRC-1:0] evtPulse,
  input  logic               engineBusy,
  output logic               irqReq,
  output logic               coreRst,
  output logic               busyOut,
  output logic               rxTrigEn
);

  regStrobe_t strb;
  rdSel_e     rdSel;

  isr_decode #(
    .ADDR_W   (ADDR_W),
    .CTRL_ADDR(CTRL_ADDR),
    .STAT_ADDR(STAT_ADDR)
  ) i_decode (
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .strb     (strb),
    .rdSel    (rdSel)
  );

  isr_datapath i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .rdSel     (rdSel),
    .evtPulse  (evtPulse),
    .engineBusy(engineBusy),
    .rdData    (regRdData),
    .irqReq    (irqReq),
    .coreRst   (coreRst),
    .busyOut   (busyOut),
    .rxTrigEn  (rxTrigEn)
  );

  assert_srst_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ctrlWr && strb.data[SRST_BIT]) |=> (coreRst && !busyOut));
  assert_quiet_irq_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.statWr && (&(strb.data | ~SRC_MASK)) && !(|evtPulse)) |=> !irqReq);

endmodule

// File: tb/test_isr_unit.sv
module test_isr_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [5:0]  evtPulse = '0;
  logic        engineBusy = 1'b0;
  logic        irqReq, coreRst, busyOut, rxTrigEn;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  isr_unit i_isr_unit (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .evtPulse(evtPulse),
    .engineBusy(engineBusy), .irqReq(irqReq), .coreRst(coreRst),
    .busyOut(busyOut), .rxTrigEn(rxTrigEn)
  );

  // Source index to bit position, per R2
  function automatic logic [31:0] spread(input logic [5:0] v);
    logic [31:0] w;
    w = '0;
    w[0] = v[0]; w[4] = v[1]; w[8] = v[2];
    w[9] = v[3]; w[12] = v[4]; w[13] = v[5];
    return w;
  endfunction

  localparam logic [31:0] ALL_SRC = 32'h0000_3311;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic pulse(input logic [5:0] e);
    @(negedge clk);
    evtPulse = e;
    @(negedge clk);
    evtPulse = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd0, v); check("R1 ctrl", v, 32'h0);
    rd(4'd4, v); check("R1 stat", v, 32'h0);
    check("R1 irq", {31'b0, irqReq}, 32'h0);
    check("R1 core reset", {31'b0, coreRst}, 32'h0);
    check("R1 rxtrig", {31'b0, rxTrigEn}, 32'h0);

    // R6 control readback, reserved bits read 0
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0, v); check("R6 ctrl all ones", v, ALL_SRC | 32'h1008_0000);
    wr(4'd0, 32'h0);
    rd(4'd0, v); check("R6 ctrl zero", v, 32'h0);

    // R2/R5/R9: sweep every enable mask against every status mask
    for (int en = 0; en < 64; en++) begin
      wr(4'd0, spread(6'(en)));
      for (int st = 0; st < 64; st++) begin
        wr(4'd4, 32'hFFFF_FFFF);
        pulse(6'(st));
        rd(4'd4, v); check("R2 latch", v, spread(6'(st)));
        check("R5 irq", {31'b0, irqReq}, {31'b0, ((en & st) != 0)});
      end
      rd(4'd0, v); check("R9 ctrl kept", v, spread(6'(en)));
    end

    // R3/R9: every clear mask, reserved bits toggled on odd masks
    wr(4'd0, 32'h0);
    for (int m = 0; m < 64; m++) begin
      pulse(6'h3F);
      wr(4'd4, spread(6'(m)) | ((m % 2) ? ~ALL_SRC : 32'h0));
      rd(4'd4, v); check("R3 w1c", v, spread(~6'(m)));
      rd(4'd0, v); check("R9 ctrl untouched", v, 32'h0);
    end

    // R4 event beats clear in the same cycle
    for (int i = 0; i < 6; i++) begin
      wr(4'd4, 32'hFFFF_FFFF);
      @(negedge clk);
      regWrEn = 1'b1; regAddr = 4'd4; regWrData = 32'hFFFF_FFFF;
      evtPulse = 6'(1 << i);
      @(negedge clk);
      regWrEn = 1'b0; evtPulse = '0;
      rd(4'd4, v); check("R4 event wins", v, spread(6'(1 << i)));
    end

    // R7 software reset
    engineBusy = 1'b1;
    wr(4'd0, 32'h0);
    check("R7 busy follows", {31'b0, busyOut}, 32'h1);
    wr(4'd0, 32'h1000_0000);
    check("R7 core reset", {31'b0, coreRst}, 32'h1);
    check("R7 busy forced low", {31'b0, busyOut}, 32'h0);
    wr(4'd0, 32'h0);
    check("R7 release", {31'b0, busyOut}, 32'h1);
    check("R7 core run", {31'b0, coreRst}, 32'h0);
    engineBusy = 1'b0;

    // R8 receive-trigger enable
    wr(4'd0, 32'h0008_0000);
    check("R8 rxtrig on", {31'b0, rxTrigEn}, 32'h1);
    wr(4'd0, 32'h0);
    check("R8 rxtrig off", {31'b0, rxTrigEn}, 32'h0);

    // R10 unmapped address
    wr(4'd0, ALL_SRC);
    wr(4'd4, 32'hFFFF_FFFF);
    pulse(6'h15);
    wr(4'd8, 32'hFFFF_FFFF);
    rd(4'd0, v); check("R10 ctrl kept", v, ALL_SRC);
    rd(4'd4, v); check("R10 stat kept", v, spread(6'h15));
    rd(4'd8, v); check("R10 read zero", v, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule